// File: doc/BRIEF.md
# Grouped Edge-Triggered Port Interrupt Flags

This block watches a set of input pins organised into groups of eight and turns selected signal transitions into sticky interrupt flags. Each pin has three programmable properties: an edge polarity bit choosing rising or falling transitions, an enable bit, and a flag that latches when the chosen transition is seen. Software clears a flag by writing a one to its position.

For quick dispatch, each group exposes a summary bit. The summary bit is high while any flag in that group is set and that pin is enabled. Software reads the summary register first to find the active group, then reads that group's flag register to find the pin. The summary has no storage of its own, so clearing the pin flags clears it. A single interrupt request line goes to the system interrupt controller.

Pins are treated as asynchronous. They pass through a synchronizer chain before edge detection. The register port is a simple single-cycle write strobe with a combinational read path.

Top module: `port_irq_grouper`

## Requirements
- R1: A pin whose polarity bit is 0 sets its flag only on a low-to-high transition. A pin whose polarity bit is 1 sets its flag only on a high-to-low transition.
- R2: A flag latches on a qualifying transition even while the pin's enable bit is 0.
- R3: Writing the flag register clears exactly those flags whose data bit is 1. Flags written with 0 keep their value.
- R4: If a qualifying transition and a clearing write hit the same pin in the same cycle, the flag ends up set.
- R5: Summary bit g is 1 exactly when some pin of group g has both its flag and its enable bit set. A flagged but disabled pin leaves the summary at 0.
- R6: The summary clears as soon as the qualifying flags are cleared. Writes to the summary address change neither the summary nor any flag.
- R7: The interrupt request is 1 one cycle after any summary bit is 1, and 0 one cycle after all summary bits are 0.
- R8: After reset, all polarity, enable, flag and summary registers read 0 and the interrupt request is 0.
- R9: A pin change applied between two clock edges is reflected in its flag after the third rising edge and not before. The request follows one edge later.
- R10: Register address = {group[GRP_W-1:0], sel[1:0]}. sel 0 is polarity (read/write), sel 1 is enable (read/write), and sel 2 is flags (read, write-1-to-clear). Group index NUM_GROUPS with sel 0 is the read-only summary, with group g in bit g. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_GROUPS*PINS | Raw pin levels, group g at bits [g*PINS +: PINS] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pin transition that latches a flag and a software write-1-to-clear to that same flag can land in one clock cycle. The bench provokes this by changing a pin and then counting clock edges through the synchronizer. It raises the clearing write strobe in exactly the cycle in which the edge detector fires. It then reads the flag back and expects it set. A control run, where the clear arrives one cycle later, must leave the flag clear.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
   typedef enum logic [1:0] {
      SEL_POLARITY = 2'd0,
      SEL_ENABLE   = 2'd1,
      SEL_FLAGS    = 2'd2,
      SEL_SPARE    = 2'd3
   } reg_sel_e;

   localparam int SEL_W = 2;
endpackage

// File: rtl/pin_sync_chain.sv
module pin_sync_chain #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync_chain: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pin_sync_chain: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_group_flags.sv
module pin_group_flags #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin_sync_i,
   input  logic            pol_we_i,
   input  logic            en_we_i,
   input  logic            clr_we_i,
   input  logic [PINS-1:0] wdata_i,
   output logic [PINS-1:0] polarity_o,
   output logic [PINS-1:0] enable_o,
   output logic [PINS-1:0] flags_o,
   output logic            summary_o
);
   if (PINS < 1) begin : g_bad_pins
      $error("pin_group_flags: PINS must be positive");
   end

   logic [PINS-1:0] prev_q;
   logic [PINS-1:0] hit;
   logic [PINS-1:0] clr;
   logic [PINS-1:0] pol_q, en_q, flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_sync_i;
   end

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic rise, fall;
      assign rise   = pin_sync_i[p] & ~prev_q[p];
      assign fall   = ~pin_sync_i[p] & prev_q[p];
      assign hit[p] = pol_q[p] ? fall : rise;
   end

   assign clr = clr_we_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         if (pol_we_i) pol_q <= wdata_i;
         if (en_we_i)  en_q  <= wdata_i;
         flag_q <= (flag_q & ~clr) | hit;
      end
   end

   assign polarity_o = pol_q;
   assign enable_o   = en_q;
   assign flags_o    = flag_q;
   assign summary_o  = |(flag_q & en_q);

   AST_FLAG_SETS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((flags_o & $past(hit)) == $past(hit)))
      else $error("flag missed an edge"); // R1
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~hit) != '0) |=> ((flags_o & $past(clr & ~hit)) == '0))
      else $error("flag not cleared"); // R3
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & hit) != '0) |=> ((flags_o & $past(clr & hit)) == $past(clr & hit)))
      else $error("clear beat set"); // R4
   AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(hit)) == '0))
      else $error("flag set without edge"); // R2
endmodule

// File: rtl/port_irq_grouper.sv
module port_irq_grouper
   import port_irq_pkg::*;
#(
   parameter int NUM_GROUPS  = 2,
   parameter int PINS        = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int GRP_W      = $clog2(NUM_GROUPS + 1),
   localparam int ADDR_W     = GRP_W + SEL_W,
   localparam int TOTAL_PINS = NUM_GROUPS * PINS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOTAL_PINS-1:0] pins_i,
   input  logic                  reg_wr_i,
   input  logic [ADDR_W-1:0]     reg_addr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   output logic                  irq_o
);
   if (PINS > DATA_W) begin : g_bad_data_w
      $error("port_irq_grouper: DATA_W must hold one group");
   end
   if (NUM_GROUPS > DATA_W) begin : g_bad_groups
      $error("port_irq_grouper: DATA_W must hold the summary vector");
   end
   if (NUM_GROUPS < 1) begin : g_bad_count
      $error("port_irq_grouper: need at least one group");
   end

   logic [TOTAL_PINS-1:0] pins_sync;
   logic [GRP_W-1:0]      grp_idx;
   reg_sel_e              sel;
   logic [PINS-1:0]       pol_v  [NUM_GROUPS];
   logic [PINS-1:0]       en_v   [NUM_GROUPS];
   logic [PINS-1:0]       flag_v [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] summary;
   logic                  irq_q;
   logic                  any_enabled_flag;

   assign grp_idx = reg_addr_i[ADDR_W-1:SEL_W];
   assign sel     = reg_sel_e'(reg_addr_i[SEL_W-1:0]);

   pin_sync_chain #(
      .WIDTH  (TOTAL_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pins_i),
      .sync_o (pins_sync)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      logic hit_grp;
      assign hit_grp = reg_wr_i && (grp_idx == GRP_W'(g));

      pin_group_flags #(
         .PINS (PINS)
      ) u_group (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_sync_i (pins_sync[g*PINS +: PINS]),
         .pol_we_i   (hit_grp && (sel == SEL_POLARITY)),
         .en_we_i    (hit_grp && (sel == SEL_ENABLE)),
         .clr_we_i   (hit_grp && (sel == SEL_FLAGS)),
         .wdata_i    (reg_wdata_i[PINS-1:0]),
         .polarity_o (pol_v[g]),
         .enable_o   (en_v[g]),
         .flags_o    (flag_v[g]),
         .summary_o  (summary[g])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_idx == GRP_W'(g)) begin
            case (sel)
               SEL_POLARITY: reg_rdata_o[PINS-1:0] = pol_v[g];
               SEL_ENABLE:   reg_rdata_o[PINS-1:0] = en_v[g];
               SEL_FLAGS:    reg_rdata_o[PINS-1:0] = flag_v[g];
               default:      reg_rdata_o = '0;
            endcase
         end
      end
      if (grp_idx == GRP_W'(NUM_GROUPS) && sel == SEL_POLARITY)
         reg_rdata_o[NUM_GROUPS-1:0] = summary;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |summary;
   end
   assign irq_o = irq_q;

   always_comb begin
      any_enabled_flag = 1'b0;
      for (int g = 0; g < NUM_GROUPS; g++)
         any_enabled_flag = any_enabled_flag | (|(flag_v[g] & en_v[g]));
   end

   AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(any_enabled_flag))
      else $error("request without enabled flag"); // R7
   AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      any_enabled_flag |=> irq_o)
      else $error("request missing"); // R7
endmodule

// File: tb/port_irq_grouper_tb.sv
`timescale 1ns/1ps
module port_irq_grouper_tb;
   localparam int NG = 2;
   localparam int P  = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*P-1:0] pins = '0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   port_irq_grouper u_dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   // {group, polarity, enable, start level, end level}
   localparam logic [39:0] VEC [6] = '{
      {8'd0, 8'h00, 8'hFF, 8'h00, 8'h0F},
      {8'd0, 8'hFF, 8'hFF, 8'hFF, 8'h0F},
      {8'd1, 8'h00, 8'h00, 8'h00, 8'hFF},
      {8'd1, 8'hF0, 8'h0F, 8'hA5, 8'h5A},
      {8'd0, 8'h0F, 8'hF0, 8'h3C, 8'hC3},
      {8'd1, 8'h00, 8'h80, 8'h7F, 8'h80}
   };

   function automatic logic [AW-1:0] ad(int g, int s);
      return AW'(g * 4 + s);
   endfunction

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_reg(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      for (int g = 0; g < NG; g++) wr_reg(ad(g, 2), 8'hFF);
   endtask

   task automatic summary_line();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary_line();
      $finish;
   end

   initial begin
      logic [7:0] d;
      idle(3);
      // R8: reset state
      for (int g = 0; g < NG; g++)
         for (int s = 0; s < 3; s++) begin
            rd_reg(ad(g, s), d);
            check("R8 reset register", d, 8'h00);
         end
      rd_reg(ad(NG, 0), d);
      check("R8 reset summary", d, 8'h00);
      check("R8 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      idle(2);

      // table walk: R1 R2 R5 R7 R10
      for (int v = 0; v < 6; v++) begin
         int g;
         logic [7:0] pol, en, st, en_lvl, expf, exps;
         g = int'(VEC[v][39:32]);
         pol = VEC[v][31:24]; en = VEC[v][23:16];
         st = VEC[v][15:8];  en_lvl = VEC[v][7:0];
         for (int k = 0; k < NG; k++) wr_reg(ad(k, 1), 8'h00);
         wr_reg(ad(g, 0), pol);
         @(negedge clk); pins[g*P +: P] = st;
         idle(5);
         clear_all();
         wr_reg(ad(g, 1), en);
         @(negedge clk); pins[g*P +: P] = en_lvl;
         idle(5);
         expf = (~pol & ~st & en_lvl) | (pol & st & ~en_lvl);
         exps = ((expf & en) != 0) ? 8'(1 << g) : 8'h00;
         rd_reg(ad(g, 0), d); check("R10 polarity readback", d, pol);
         rd_reg(ad(g, 1), d); check("R10 enable readback", d, en);
         rd_reg(ad(g, 2), d); check("R1 R2 table flags", d, expf);
         rd_reg(ad(NG, 0), d); check("R5 table summary", d, exps);
         check("R7 table irq", {7'd0, irq}, {7'd0, exps != 0});
      end

      // R9 latency and R7 request timing
      for (int k = 0; k < NG; k++) wr_reg(ad(k, 1), 8'h00);
      @(negedge clk); pins = '0;
      wr_reg(ad(0, 0), 8'h00);
      idle(5);
      clear_all();
      wr_reg(ad(0, 1), 8'h01);
      @(negedge clk); pins[0] = 1'b1; addr = ad(0, 2);
      @(posedge clk); @(posedge clk);
      @(negedge clk); #1; check("R9 flag before third edge", rdata, 8'h00);
      @(posedge clk);
      @(negedge clk); #1; check("R9 flag after third edge", rdata, 8'h01);
      check("R7 irq not yet", {7'd0, irq}, 8'h00);
      @(negedge clk); #1; check("R7 irq one edge later", {7'd0, irq}, 8'h01);

      // R3: write 0 keeps, write 1 clears
      wr_reg(ad(0, 2), 8'hFE);
      rd_reg(ad(0, 2), d); check("R3 zero bit keeps flag", d, 8'h01);
      // R6: writes to the summary address are ignored
      wr_reg(ad(NG, 0), 8'h00);
      rd_reg(ad(NG, 0), d); check("R6 summary write ignored", d, 8'h01);
      rd_reg(ad(0, 2), d); check("R6 flags kept after summary write", d, 8'h01);
      wr_reg(ad(0, 2), 8'h01);
      rd_reg(ad(0, 2), d); check("R3 one bit clears flag", d, 8'h00);
      rd_reg(ad(NG, 0), d); check("R6 summary cleared with flags", d, 8'h00);
      idle(1);
      check("R7 irq drops", {7'd0, irq}, 8'h00);

      // R5: enabling after the flag latched raises the summary
      wr_reg(ad(0, 1), 8'h00);
      @(negedge clk); pins[1] = 1'b1;
      idle(5);
      rd_reg(ad(NG, 0), d); check("R5 disabled flag no summary", d, 8'h00);
      rd_reg(ad(0, 2), d); check("R2 disabled pin still flags", d, 8'h02);
      wr_reg(ad(0, 1), 8'h02);
      rd_reg(ad(NG, 0), d); check("R5 summary after enable", d, 8'h01);
      clear_all();

      // R4: edge and clear in the same cycle, set wins
      @(negedge clk); pins[0] = 1'b0;
      idle(5);
      clear_all();
      @(negedge clk); pins[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); wr = 1'b1; addr = ad(0, 2); wdata = 8'h01;
      @(posedge clk);
      @(negedge clk); wr = 1'b0; #1;
      check("R4 set wins over clear", rdata, 8'h01);
      // control: clear one cycle after the edge
      wr_reg(ad(0, 2), 8'h01);
      @(negedge clk); pins[0] = 1'b0;
      idle(5);
      @(negedge clk); pins[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk); wr = 1'b1; addr = ad(0, 2); wdata = 8'h01;
      @(negedge clk); wr = 1'b0; #1;
      check("R4 later clear removes flag", rdata, 8'h00);

      // R1: opposite edge ignored
      @(negedge clk); pins[0] = 1'b0;
      idle(5);
      rd_reg(ad(0, 2), d); check("R1 falling ignored in rising mode", d, 8'h00);
      rd_reg(ad(3, 1), d); check("R10 unmapped reads zero", d, 8'h00);

      summary_line();
      $finish;
   end
endmodule